// File: doc/BRIEF.md
# Channel-Grouping Readout Address Generator

This block reads back a record of four-channel samples from a memory that holds them channel-interleaved: one word per channel for sample 0, then one per channel for sample 1, and so on. The stored area is a circular region written continuously, described by a base address and a length. A readout is started with a one-cycle pulse. The block then produces the read request and address sequence for a synchronous memory, collects the returned words, and presents them on a ready/valid stream. Each word carries its channel index and an end-of-record flag.

A mode input selects the output order. With the mode input low, words come out in stored order. With the mode input high, the record is regrouped per channel: all samples of the first channel in time order, then all of the second, third and fourth. The host therefore receives data it can use without reordering it. Addresses that run past the end of the region wrap back to its base.

The configuration is captured when a readout begins. Output back-pressure stalls address generation without losing or repeating any word. The memory read latency is a parameter (`RD_LAT`, default 1 cycle from request to data).

Top module: `chgrp_readout`

## Requirements
- R1: With the mode input low, output word k (k = 0 .. 4N-1, N = samples per channel) is read from address base + ((start - base + k) mod len), and its channel field equals k mod 4.
- R2: With the mode input high, words come out channel by channel (field 0, 1, 2, 3), with samples in time order inside each channel. The word for channel field c and sample n is read from address base + ((start - base + 4n + c) mod len).
- R3: Every read request addresses a location in [base, base + len). The region is taken as len >= 4 with the start address inside it.
- R4: A readout delivers exactly 4N words. The channel field is 2 bits, where 0 to 3 stand for the first to the fourth channel. The last flag is high only on the final word, which always has channel field 3 and sample N-1.
- R5: While a word is valid and not accepted, its data, channel field and last flag stay unchanged. No word is skipped or duplicated under any ready pattern.
- R6: A start pulse that arrives while a readout is active is ignored. The running sequence and its latched configuration are unaffected.
- R7: busy goes high in the cycle after an accepted start. It stays high until the cycle after the last word is accepted. A start with a sample count of zero is ignored.
- R8: After reset, busy, out_valid and mem_req are low. While idle, no request and no valid word appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle readout start pulse |
| grp_mode_i | input | 1 | 1 = channel-grouped order, 0 = stored order |
| start_addr_i | input | AW | Address of the first stored word (channel 1, sample 0) |
| region_base_i | input | AW | Lowest address of the circular region |
| region_len_i | input | AW | Number of words in the circular region |
| nsamp_i | input | NW | Samples per channel to read |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Read data, RD_LAT cycles after the request |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word accepted when high with valid |
| out_data_o | output | DW | Output sample |
| out_chan_o | output | 2 | Channel field of the output word |
| out_last_o | output | 1 | Final word of the readout |
| busy_o | output | 1 | Readout in progress |

## Verification
busy is due one edge after the start is sampled. The first read request appears in that same cycle. Each returned word is visible on the output RD_LAT + 1 edges after its request: RD_LAT edges for the memory and one for the output buffer. The bench does not predict the exact cycle of each word. It samples on the falling edge and compares the request address whenever a request is seen. It compares the output word whenever a handshake is seen, each against the next entry of a queue built from the requirements. busy is compared against a model updated with the same one-edge delay. Words held under a stall are compared against their values from the previous cycle.

// File: rtl/chgrp_pkg.sv
package chgrp_pkg;
  localparam int NUM_CH = 4;
  localparam int CHW    = 2;

  typedef logic [CHW-1:0] ch_idx_t;

  typedef struct packed {
    ch_idx_t chan;
    logic    last;
  } word_tag_t;

  localparam int TAGW = $bits(word_tag_t);
endpackage

// File: rtl/chgrp_seq.sv
// Read order sequencer: walks (channel, sample) in the selected order and
// keeps the position relative to the region base, wrapping incrementally.
module chgrp_seq
  import chgrp_pkg::*;
#(
  parameter int AW = 8,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          grp_i,
  input  logic [AW-1:0] start_rel_i,
  input  logic [AW-1:0] len_i,
  input  logic [NW-1:0] nsamp_i,
  input  logic          adv_i,
  output logic          active_o,
  output logic [AW-1:0] rel_o,
  output ch_idx_t       chan_o,
  output logic          last_o
);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NUM_CH - 1);

  logic          act_q;
  logic          grp_q;
  logic [AW-1:0] srel_q;
  logic [AW-1:0] len_q;
  logic [NW-1:0] nlast_q;
  ch_idx_t       chan_q;
  logic [NW-1:0] samp_q;
  logic [AW-1:0] rel_q;
  logic          samp_end;

  function automatic logic [AW-1:0] wrap_pos(input logic [AW:0] x, input logic [AW-1:0] l);
    if (x >= {1'b0, l}) return AW'(x - {1'b0, l});
    else                return x[AW-1:0];
  endfunction

  assign samp_end = (samp_q == nlast_q);
  assign last_o   = (chan_q == LAST_CH) && samp_end;
  assign active_o = act_q;
  assign rel_o    = rel_q;
  assign chan_o   = chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      grp_q   <= 1'b0;
      srel_q  <= '0;
      len_q   <= '0;
      nlast_q <= '0;
      chan_q  <= '0;
      samp_q  <= '0;
      rel_q   <= '0;
    end else if (load_i) begin
      act_q   <= 1'b1;
      grp_q   <= grp_i;
      srel_q  <= start_rel_i;
      len_q   <= len_i;
      nlast_q <= nsamp_i - NW'(1);
      chan_q  <= '0;
      samp_q  <= '0;
      rel_q   <= start_rel_i;
    end else if (adv_i && act_q) begin
      if (last_o) begin
        act_q <= 1'b0;
      end else if (grp_q) begin
        if (samp_end) begin
          chan_q <= chan_q + CHW'(1);
          samp_q <= '0;
          rel_q  <= wrap_pos({1'b0, srel_q} + (AW+1)'(chan_q) + (AW+1)'(1), len_q);
        end else begin
          samp_q <= samp_q + NW'(1);
          rel_q  <= wrap_pos({1'b0, rel_q} + (AW+1)'(NUM_CH), len_q);
        end
      end else begin
        chan_q <= chan_q + CHW'(1);
        if (chan_q == LAST_CH) samp_q <= samp_q + NW'(1);
        rel_q  <= wrap_pos({1'b0, rel_q} + (AW+1)'(1), len_q);
      end
    end
  end

  AST_REL_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (rel_q < len_q)); // R3
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !act_q); // R6
  AST_GRP_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (act_q && adv_i && grp_q && !samp_end) |=> (chan_q == $past(chan_q))); // R2
endmodule

// File: rtl/chgrp_tagpipe.sv
// Carries the channel/last tag of each request alongside the memory latency.
module chgrp_tagpipe #(
  parameter int LAT = 1,
  parameter int TW  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_vld_i,
  input  logic [TW-1:0]               in_tag_i,
  output logic                        out_vld_o,
  output logic [TW-1:0]               out_tag_o,
  output logic [$clog2(LAT+2)-1:0]    inflight_o
);
  localparam int CW = $clog2(LAT+2);

  logic [LAT-1:0] vld_q;
  logic [TW-1:0]  tag_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) vld_q[g] <= 1'b0;
        else     vld_q[g] <= in_vld_i;
        tag_q[g] <= in_tag_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) vld_q[g] <= 1'b0;
        else     vld_q[g] <= vld_q[g-1];
        tag_q[g] <= tag_q[g-1];
      end
    end
  end

  always_comb begin
    inflight_o = '0;
    for (int i = 0; i < LAT; i++) inflight_o = inflight_o + CW'(vld_q[i]);
  end

  assign out_vld_o = vld_q[LAT-1];
  assign out_tag_o = tag_q[LAT-1];
endmodule

// File: rtl/chgrp_ofifo.sv
// Small output buffer absorbing words already requested when the sink stalls.
module chgrp_ofifo #(
  parameter int DEPTH = 4,
  parameter int W     = 19
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 dout_o,
  output logic                         nempty_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  assign do_pop = pop_i && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PMAX) ? '0 : wp_q + PW'(1);
      if (do_pop) rp_q <= (rp_q == PMAX) ? '0 : rp_q + PW'(1);
      if (push_i && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (!push_i && do_pop) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign dout_o   = mem_q[rp_q];
  assign nempty_o = (cnt_q != '0);
  assign count_o  = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |-> (cnt_q < CW'(DEPTH))); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/chgrp_readout.sv
module chgrp_readout
  import chgrp_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int NW         = 8,
  parameter int RD_LAT     = 1,
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          grp_mode_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] region_base_i,
  input  logic [AW-1:0] region_len_i,
  input  logic [NW-1:0] nsamp_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o,
  output logic [1:0]    out_chan_o,
  output logic          out_last_o,
  output logic          busy_o
);
  localparam int FW  = DW + TAGW;
  localparam int ICW = $clog2(RD_LAT+2);
  localparam int FCW = $clog2(FIFO_DEPTH+1);

  logic            busy_q;
  logic [AW-1:0]   base_q;
  logic            load;
  logic            issue;
  logic            fire;
  logic            seq_act;
  logic [AW-1:0]   seq_rel;
  ch_idx_t         seq_chan;
  logic            seq_last;
  word_tag_t       req_tag, ret_tag;
  logic [TAGW-1:0] ret_tag_bits;
  logic            ret_vld;
  logic [ICW-1:0]  inflight;
  logic [FCW-1:0]  fifo_cnt;
  logic [FW-1:0]   fifo_dout;

  assign load  = start_i && !busy_q && (nsamp_i != '0);
  assign issue = seq_act && ((int'(fifo_cnt) + int'(inflight)) < FIFO_DEPTH);
  assign fire  = out_valid_o && out_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      base_q <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      base_q <= region_base_i;
    end else if (fire && out_last_o) begin
      busy_q <= 1'b0;
    end
  end

  chgrp_seq #(.AW(AW), .NW(NW)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .grp_i       (grp_mode_i),
    .start_rel_i (start_addr_i - region_base_i),
    .len_i       (region_len_i),
    .nsamp_i     (nsamp_i),
    .adv_i       (issue),
    .active_o    (seq_act),
    .rel_o       (seq_rel),
    .chan_o      (seq_chan),
    .last_o      (seq_last)
  );

  assign mem_req_o  = issue;
  assign mem_addr_o = base_q + seq_rel;

  assign req_tag.chan = seq_chan;
  assign req_tag.last = seq_last;

  chgrp_tagpipe #(.LAT(RD_LAT), .TW(TAGW)) pipe_i (
    .clk        (clk),
    .rst        (rst),
    .in_vld_i   (issue),
    .in_tag_i   (req_tag),
    .out_vld_o  (ret_vld),
    .out_tag_o  (ret_tag_bits),
    .inflight_o (inflight)
  );
  assign ret_tag = word_tag_t'(ret_tag_bits);

  chgrp_ofifo #(.DEPTH(FIFO_DEPTH), .W(FW)) fifo_i (
    .clk      (clk),
    .rst      (rst),
    .push_i   (ret_vld),
    .din_i    ({mem_rdata_i, ret_tag}),
    .pop_i    (fire),
    .dout_o   (fifo_dout),
    .nempty_o (out_valid_o),
    .count_o  (fifo_cnt)
  );

  assign out_data_o = fifo_dout[FW-1:TAGW];
  assign out_chan_o = fifo_dout[TAGW-1:1];
  assign out_last_o = fifo_dout[0];
  assign busy_o     = busy_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
      && $stable(out_chan_o) && $stable(out_last_o))); // R5
  AST_LAST_IS_CH4: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && out_last_o) |-> (out_chan_o == 2'd3)); // R4
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    (fire && out_last_o) |=> !busy_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!out_valid_o && !mem_req_o)); // R8
endmodule

// File: tb/chgrp_readout_tb.sv
module chgrp_readout_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          grp = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] len = 8'd4;
  logic [NW-1:0] nsamp = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic [1:0]    out_chan;
  logic          out_last;
  logic          busy;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  bit run_chk = 0;
  int rdy_mode = 0;

  bit m_busy = 0;
  bit m_grp = 0;
  int q_addr[$];
  int q_data[$];
  int q_chan[$];
  int q_last[$];

  bit prev_stall = 0;
  logic [DW-1:0] p_data;
  logic [1:0] p_chan;
  logic p_last;
  int lo_b, hi_len;

  chgrp_readout dut_i (
    .clk(clk), .rst(rst), .start_i(start), .grp_mode_i(grp),
    .start_addr_i(saddr), .region_base_i(base), .region_len_i(len),
    .nsamp_i(nsamp), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_chan_o(out_chan), .out_last_o(out_last),
    .busy_o(busy)
  );

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return (DW'(a) * 16'd37) ^ 16'h5A3C;
  endfunction

  always @(posedge clk) if (mem_req) mem_rdata <= memval(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic build(input int s, input int b, input int l, input int n, input bit g);
    int rel0, off, a;
    rel0 = (s - b) & 255;
    q_addr.delete(); q_data.delete(); q_chan.delete(); q_last.delete();
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < n; k++) begin
        int ch, sm;
        if (g) begin ch = c; sm = k; end
        else begin ch = (c * n + k) % 4; sm = (c * n + k) / 4; end
        off = 4 * sm + ch;
        a = (b + ((rel0 + off) % l)) & 255;
        q_addr.push_back(a);
        q_data.push_back(int'(memval(AW'(a))));
        q_chan.push_back(ch);
        q_last.push_back((ch == 3 && sm == n - 1) ? 1 : 0);
      end
    end
    lo_b = b; hi_len = l;
  endtask

  // Reference model, compared every cycle on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rst && run_chk) begin
      chk(busy == m_busy, "R7 busy", busy, m_busy);
      if (!m_busy) chk(!out_valid && !mem_req, "R8 idle quiet", {out_valid, mem_req}, 0);
      if (mem_req) begin
        int rel;
        rel = (int'(mem_addr) - lo_b) & 255;
        chk(rel < hi_len, "R3 address in region", mem_addr, lo_b);
        if (q_addr.size() == 0) chk(0, "R4 extra request", mem_addr, -1);
        else begin
          int ea;
          ea = q_addr.pop_front();
          chk(int'(mem_addr) == ea, m_grp ? "R2 grouped address" : "R1 stored-order address", mem_addr, ea);
        end
      end
      if (prev_stall)
        chk(out_valid && out_data == p_data && out_chan == p_chan && out_last == p_last,
            "R5 held under stall", out_data, p_data);
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) chk(0, "R4 extra word", out_data, -1);
        else begin
          int ed, ec, el;
          ed = q_data.pop_front(); ec = q_chan.pop_front(); el = q_last.pop_front();
          chk(int'(out_data) == ed, m_grp ? "R2 grouped data" : "R1 stored-order data", out_data, ed);
          chk(int'(out_chan) == ec, m_grp ? "R2 channel field" : "R1 channel field", out_chan, ec);
          chk(int'(out_last) == el, "R4 last flag", out_last, el);
        end
      end
      if (start && !m_busy && nsamp != 0) begin
        m_busy = 1; m_grp = grp;
        build(saddr, base, len, nsamp, grp);
      end else if (out_valid && out_ready && out_last) m_busy = 0;
      prev_stall = out_valid && !out_ready;
      p_data = out_data; p_chan = out_chan; p_last = out_last;
    end
  end

  // Ready pattern driver
  always @(posedge clk) begin
    #2;
    if (rdy_mode == 0) out_ready = 1'b1;
    else out_ready = ($urandom % 3) != 0;
  end

  // Watchdog
  always @(negedge clk) if (cycles > 100000) begin
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic wait_idle();
    int t = 0;
    do begin @(negedge clk); t++; end while ((busy || m_busy) && t < 5000);
    @(negedge clk);
    chk(q_data.size() == 0 && q_addr.size() == 0, "R4 word count", q_data.size(), 0);
  endtask

  task automatic job(input int s, input int b, input int l, input int n, input bit g,
                     input int rm, input bit restart);
    rdy_mode = rm;
    @(posedge clk); #2;
    saddr = AW'(s); base = AW'(b); len = AW'(l); nsamp = NW'(n); grp = g; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (restart) begin
      repeat (4) @(posedge clk);
      #2;
      // R6: second start with a different setup while active
      saddr = AW'(b + 1); grp = !g; nsamp = NW'(1); start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(!busy && !out_valid && !mem_req, "R8 reset state", {busy, out_valid, mem_req}, 0);
    run_chk = 1;
    job(20, 16, 40, 3, 0, 0, 0);    // R1 plain
    job(20, 16, 40, 3, 1, 0, 0);    // R2 plain
    job(105, 100, 10, 3, 0, 0, 0);  // R1 + R3 wrap
    job(107, 100, 10, 2, 1, 0, 0);  // R2 + R3 wrap
    job(240, 200, 50, 5, 1, 1, 0);  // R5 random stall, grouped
    job(3, 0, 13, 4, 0, 1, 0);      // R5 random stall, stored order
    job(50, 48, 8, 1, 1, 0, 0);     // R4 single sample per channel
    job(10, 8, 30, 6, 1, 1, 1);     // R6 restart ignored
    // R7: zero-sample start ignored
    @(posedge clk); #2;
    nsamp = '0; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !out_valid, "R7 zero count ignored", busy, 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule